// File: doc/BRIEF.md
# PWM Input Capture Unit

This block measures an external pulse train by timestamping its edges against one shared counter. The counter advances once every PSC+1 clocks and wraps to zero after reaching a programmable top value. Four input pins are split into two pairs. Within a pair, a select bit picks one pin, and that pin drives two capture units. The first unit latches the counter on rising edges and the second on falling edges. An optional edge divider makes a pair capture only on every 2nd, 4th or 8th qualifying edge.

Each rising-edge capture raises a valid/ready beat on that pair's output stream. The beat carries both capture registers of the pair (rising value, falling value), so a consumer gets the values it needs for period and high time from a single event. Software takes two successive beats {r0, f_prev} and {r1, f1}. It then computes period = r1 - r0 and high = f1 - r0, adding the wrap span when a value went down. If the high value comes out larger than the period, the period is subtracted from it.

Back-pressure rules:
- A beat stays valid until it is accepted.
- The data lanes always show the live capture registers. A newer capture made while a beat is pending replaces the data in place, and the overcapture flag marks this.
- Acceptance (valid and ready high in the same cycle) counts as reading both registers of the pair.

Top module: `pwmcap_unit`

## Requirements
- R1: One cycle after a rising-edge capture event, the pair's rise lane holds the counter value from the cycle in which the event was detected.
- R2: A falling edge of the selected pin, when it qualifies, copies the counter value into the pair's second register, which is shown on the fall lane.
- R3: Pair p reads pin 2p when its select bit is 0 and pin 2p+1 when its select bit is 1; the unselected pin has no effect.
- R4: While counting is enabled, the counter advances once every PSC+1 clocks, runs 0..TOP and then returns to 0. When counting is disabled, the counter holds its value.
- R5: A pulse on the update input loads PSC and TOP at once and clears the counter and the clock prescaler. Without that pulse, new PSC/TOP values take effect only when the counter wraps.
- R6: The 2-bit divider code n of a pair (bits 2p+1:2p of in_div) makes each of its units capture on every 2^n-th qualifying edge, counted from arming.
- R7: A unit whose arm bit is 0 never captures and restarts its edge count at zero.
- R8: A rise capture sets the pair's valid. Valid stays high until a cycle with ready high, and it drops after that cycle unless a new rise capture happens in the same cycle.
- R9: An overcapture flag (bit 2p for rise, 2p+1 for fall) is set when its unit captures while its previous value is unread. The rise value counts as unread while valid is high. The fall value counts as unread from its capture until the next acceptance. An acceptance clears both flags of the pair.
- R10: A pin edge reaches the edge detector through two synchronizer flops, so the captured counter value is the one present two clocks after the pin changed.
- R11: After reset, all valids, flags, registers and the counter are zero, and the top value is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pins | input | 2*NPAIR | External pulse inputs |
| src_sel | input | NPAIR | Per-pair pin select |
| in_div | input | 2*NPAIR | Per-pair edge divider code |
| cap_arm | input | 2*NPAIR | Per-unit capture arm (2p rise, 2p+1 fall) |
| cnt_en | input | 1 | Counter run enable |
| upd_go | input | 1 | Immediate load of PSC/TOP and clear of counter |
| psc_val | input | PSC_W | Clock prescaler setting |
| arr_val | input | CNT_W | Counter top value |
| pair_valid | output | NPAIR | Beat pending per pair |
| pair_ready | input | NPAIR | Consumer accepts the beat |
| pair_rise | output | NPAIR*CNT_W | Rise capture per pair |
| pair_fall | output | NPAIR*CNT_W | Fall capture per pair |
| ovc_flag | output | 2*NPAIR | Overcapture flag per unit |

## Verification
The hardest case to reach is a capture that lands in the same cycle as an acceptance, or while an older value is still waiting. This decides whether a flag is set and whether valid survives. The stimulus holds ready low across several pulse periods and releases it for single cycles in between. Ready also follows a rotating pattern while short pulses run, so acceptances line up with edge arrivals at many phases. A behavioural model tracks every lane, valid and flag on each clock, which catches any cycle-level difference.

// File: rtl/pwmcap_pkg.sv
package pwmcap_pkg;
  typedef enum logic [1:0] {EDIV_1 = 2'd0, EDIV_2 = 2'd1, EDIV_4 = 2'd2, EDIV_8 = 2'd3} ediv_e;

  function automatic logic [2:0] ediv_limit(input ediv_e code);
    return 3'((4'd1 << code) - 4'd1);
  endfunction
endpackage

// File: rtl/pwmcap_timebase.sv
module pwmcap_timebase #(
  parameter int CNT_W = 16,
  parameter int PSC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic             upd_go,
  input  logic [PSC_W-1:0] psc_in,
  input  logic [CNT_W-1:0] arr_in,
  output logic [CNT_W-1:0] cnt_o
);
  logic [PSC_W-1:0] pre_q, psc_q;
  logic [CNT_W-1:0] cnt_q, top_q;
  logic             step, wrap;

  assign step = cnt_en && (pre_q == psc_q);
  assign wrap = step && (cnt_q == top_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      psc_q <= '0;
      cnt_q <= '0;
      top_q <= '1;
    end else if (upd_go) begin
      pre_q <= '0;
      cnt_q <= '0;
      psc_q <= psc_in;
      top_q <= arr_in;
    end else if (cnt_en) begin
      if (step) begin
        pre_q <= '0;
        if (wrap) begin
          cnt_q <= '0;
          psc_q <= psc_in;
          top_q <= arr_in;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/pwmcap_sync_edge.sv
module pwmcap_sync_edge #(
  parameter int NPIN = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] pins_i,
  output logic [NPIN-1:0] rise_o,
  output logic [NPIN-1:0] fall_o
);
  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    logic s1_q, s2_q, s3_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
        s3_q <= 1'b0;
      end else begin
        s1_q <= pins_i[i];
        s2_q <= s1_q;
        s3_q <= s2_q;
      end
    end
    assign rise_o[i] = s2_q & ~s3_q;
    assign fall_o[i] = ~s2_q & s3_q;
  end
endmodule

// File: rtl/pwmcap_pair.sv
module pwmcap_pair
  import pwmcap_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       rise_i,
  input  logic [1:0]       fall_i,
  input  logic             sel_i,
  input  logic [1:0]       div_i,
  input  logic [1:0]       arm_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             ready_i,
  output logic             valid_o,
  output logic [CNT_W-1:0] rise_val_o,
  output logic [CNT_W-1:0] fall_val_o,
  output logic [1:0]       ovc_o,
  output logic [1:0]       cap_o
);
  logic             src_rise, src_fall, hs;
  logic [1:0]       edge_v, unread_v, cap_v, ovc_v;
  logic [2:0]       lim;
  logic             valid_q, fall_unread_q;
  logic [CNT_W-1:0] val_w [2];

  assign src_rise = sel_i ? rise_i[1] : rise_i[0];
  assign src_fall = sel_i ? fall_i[1] : fall_i[0];
  assign edge_v   = {src_fall, src_rise};
  assign lim      = ediv_limit(ediv_e'(div_i));
  assign hs       = valid_q & ready_i;
  assign unread_v = {fall_unread_q, valid_q};

  for (genvar u = 0; u < 2; u++) begin : g_unit
    logic [2:0]       ecnt_q;
    logic [CNT_W-1:0] val_q;
    logic             ovc_q;

    assign cap_v[u] = arm_i[u] & edge_v[u] & (ecnt_q >= lim);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ecnt_q <= '0;
        val_q  <= '0;
        ovc_q  <= 1'b0;
      end else begin
        if (!arm_i[u])      ecnt_q <= '0;
        else if (edge_v[u]) ecnt_q <= (ecnt_q >= lim) ? 3'd0 : ecnt_q + 3'd1;
        if (cap_v[u]) val_q <= cnt_i;
        if (hs)       ovc_q <= 1'b0;
        else if (cap_v[u] && unread_v[u]) ovc_q <= 1'b1;
      end
    end

    assign val_w[u] = val_q;
    assign ovc_v[u] = ovc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q       <= 1'b0;
      fall_unread_q <= 1'b0;
    end else begin
      valid_q       <= cap_v[0] | (valid_q & ~ready_i);
      fall_unread_q <= cap_v[1] | (fall_unread_q & ~hs);
    end
  end

  assign valid_o    = valid_q;
  assign rise_val_o = val_w[0];
  assign fall_val_o = val_w[1];
  assign ovc_o      = ovc_v;
  assign cap_o      = cap_v;
endmodule

// File: rtl/pwmcap_unit.sv
module pwmcap_unit #(
  parameter int NPAIR = 2,
  parameter int CNT_W = 16,
  parameter int PSC_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [2*NPAIR-1:0]     pins,
  input  logic [NPAIR-1:0]       src_sel,
  input  logic [2*NPAIR-1:0]     in_div,
  input  logic [2*NPAIR-1:0]     cap_arm,
  input  logic                   cnt_en,
  input  logic                   upd_go,
  input  logic [PSC_W-1:0]       psc_val,
  input  logic [CNT_W-1:0]       arr_val,
  output logic [NPAIR-1:0]       pair_valid,
  input  logic [NPAIR-1:0]       pair_ready,
  output logic [NPAIR*CNT_W-1:0] pair_rise,
  output logic [NPAIR*CNT_W-1:0] pair_fall,
  output logic [2*NPAIR-1:0]     ovc_flag
);
  localparam int NPIN = 2 * NPAIR;

  logic [CNT_W-1:0] cnt_w;
  logic [NPIN-1:0]  rise_w, fall_w, cap_w;

  pwmcap_timebase #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_tb (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .upd_go(upd_go),
    .psc_in(psc_val), .arr_in(arr_val), .cnt_o(cnt_w)
  );

  pwmcap_sync_edge #(.NPIN(NPIN)) u_sync (
    .clk(clk), .rst_n(rst_n), .pins_i(pins), .rise_o(rise_w), .fall_o(fall_w)
  );

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    pwmcap_pair #(.CNT_W(CNT_W)) u_pair (
      .clk(clk), .rst_n(rst_n),
      .rise_i(rise_w[2*p +: 2]), .fall_i(fall_w[2*p +: 2]),
      .sel_i(src_sel[p]), .div_i(in_div[2*p +: 2]), .arm_i(cap_arm[2*p +: 2]),
      .cnt_i(cnt_w), .ready_i(pair_ready[p]), .valid_o(pair_valid[p]),
      .rise_val_o(pair_rise[p*CNT_W +: CNT_W]), .fall_val_o(pair_fall[p*CNT_W +: CNT_W]),
      .ovc_o(ovc_flag[2*p +: 2]), .cap_o(cap_w[2*p +: 2])
    );
  end
endmodule

// File: rtl/pwmcap_unit_chk.sv
module pwmcap_unit_chk #(
  parameter int NPAIR = 2,
  parameter int CNT_W = 16
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   cnt_en,
  input logic                   upd_go,
  input logic [2*NPAIR-1:0]     cap_arm,
  input logic [NPAIR-1:0]       pair_valid,
  input logic [NPAIR-1:0]       pair_ready,
  input logic [NPAIR*CNT_W-1:0] pair_rise,
  input logic [2*NPAIR-1:0]     ovc_flag,
  input logic [CNT_W-1:0]       cnt_now,
  input logic [2*NPAIR-1:0]     cap_evt
);
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en && !upd_go) |=> $stable(cnt_now)); // R4
  AST_UPD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    upd_go |=> (cnt_now == '0)); // R5

  for (genvar p = 0; p < NPAIR; p++) begin : g_chk
    AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (pair_valid[p] && !pair_ready[p]) |=> pair_valid[p]); // R8
    AST_VALID_SRC: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pair_valid[p]) |-> $past(cap_evt[2*p])); // R8
    AST_RISE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      cap_evt[2*p] |=> (pair_rise[p*CNT_W +: CNT_W] == $past(cnt_now))); // R1
    AST_OVC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (pair_valid[p] && pair_ready[p]) |=> (ovc_flag[2*p +: 2] == 2'b00)); // R9
    AST_DISARMED_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      !cap_arm[2*p] |-> !cap_evt[2*p]); // R7
    AST_DISARMED_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      !cap_arm[2*p+1] |-> !cap_evt[2*p+1]); // R7
  end
endmodule

bind pwmcap_unit pwmcap_unit_chk #(.NPAIR(NPAIR), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .upd_go(upd_go), .cap_arm(cap_arm),
  .pair_valid(pair_valid), .pair_ready(pair_ready), .pair_rise(pair_rise),
  .ovc_flag(ovc_flag), .cnt_now(cnt_w), .cap_evt(cap_w)
);

// File: tb/pwmcap_unit_bench.sv
module pwmcap_unit_bench;
  localparam int NPAIR = 2;
  localparam int CNT_W = 16;
  localparam int PSC_W = 8;
  localparam int NPIN  = 2 * NPAIR;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [NPIN-1:0]        pins = '0;
  logic [NPAIR-1:0]       src_sel = '0;
  logic [NPIN-1:0]        in_div = '0;
  logic [NPIN-1:0]        cap_arm = '0;
  logic                   cnt_en = 1'b0;
  logic                   upd_go = 1'b0;
  logic [PSC_W-1:0]       psc_val = '0;
  logic [CNT_W-1:0]       arr_val = '0;
  logic [NPAIR-1:0]       pair_ready = '0;
  logic [NPAIR-1:0]       pair_valid;
  logic [NPAIR*CNT_W-1:0] pair_rise, pair_fall;
  logic [NPIN-1:0]        ovc_flag;

  pwmcap_unit #(.NPAIR(NPAIR), .CNT_W(CNT_W), .PSC_W(PSC_W)) u_pwmcap_unit (
    .clk(clk), .rst_n(rst_n), .pins(pins), .src_sel(src_sel), .in_div(in_div),
    .cap_arm(cap_arm), .cnt_en(cnt_en), .upd_go(upd_go), .psc_val(psc_val),
    .arr_val(arr_val), .pair_valid(pair_valid), .pair_ready(pair_ready),
    .pair_rise(pair_rise), .pair_fall(pair_fall), .ovc_flag(ovc_flag)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;
  string cur_req = "R11";

  // behavioural reference state
  bit [NPIN-1:0] m_s1, m_s2, m_s3;
  int m_pre, m_cnt, m_psc, m_top;
  int m_ecnt [NPIN];
  int m_reg  [NPIN];
  bit m_ovc  [NPIN];
  bit m_valid [NPAIR];
  bit m_unread [NPAIR];

  always @(posedge clk or negedge rst_n) begin : mdl
    bit cap [NPIN];
    if (!rst_n) begin
      m_s1 = '0; m_s2 = '0; m_s3 = '0;
      m_pre = 0; m_cnt = 0; m_psc = 0; m_top = (1 << CNT_W) - 1;
      for (int i = 0; i < NPIN; i++) begin m_ecnt[i] = 0; m_reg[i] = 0; m_ovc[i] = 0; end
      for (int p = 0; p < NPAIR; p++) begin m_valid[p] = 0; m_unread[p] = 0; end
    end else begin
      for (int p = 0; p < NPAIR; p++) begin
        int q, lim;
        bit re, fe, hs, old_v, old_u;
        q = 2*p + int'(src_sel[p]);
        re = m_s2[q] && !m_s3[q];
        fe = !m_s2[q] && m_s3[q];
        lim = (1 << in_div[2*p +: 2]) - 1;
        for (int k = 0; k < 2; k++) begin
          int u;
          bit e;
          u = 2*p + k;
          e = (k == 0) ? re : fe;
          cap[u] = 0;
          if (!cap_arm[u]) m_ecnt[u] = 0;
          else if (e) begin
            cap[u] = (m_ecnt[u] >= lim);
            m_ecnt[u] = cap[u] ? 0 : m_ecnt[u] + 1;
          end
        end
        old_v = m_valid[p];
        old_u = m_unread[p];
        hs = old_v && pair_ready[p];
        for (int k = 0; k < 2; k++) begin
          int u;
          bit ur;
          u = 2*p + k;
          ur = (k == 0) ? old_v : old_u;
          if (hs) m_ovc[u] = 0;
          else if (cap[u] && ur) m_ovc[u] = 1;
          if (cap[u]) m_reg[u] = m_cnt;
        end
        m_valid[p]  = cap[2*p] || (old_v && !pair_ready[p]);
        m_unread[p] = cap[2*p+1] || (old_u && !hs);
      end
      if (upd_go) begin
        m_pre = 0; m_cnt = 0; m_psc = int'(psc_val); m_top = int'(arr_val);
      end else if (cnt_en) begin
        if (m_pre == m_psc) begin
          m_pre = 0;
          if (m_cnt == m_top) begin
            m_cnt = 0; m_psc = int'(psc_val); m_top = int'(arr_val);
          end else m_cnt = m_cnt + 1;
        end else m_pre = m_pre + 1;
      end
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = pins;
    end
  end

  task automatic chk(string sig, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", cur_req, sig, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int p = 0; p < NPAIR; p++) begin
        chk("valid (R8)", int'(pair_valid[p]), int'(m_valid[p]));
        chk("rise lane (R1)", int'(pair_rise[p*CNT_W +: CNT_W]), m_reg[2*p]);
        chk("fall lane (R2)", int'(pair_fall[p*CNT_W +: CNT_W]), m_reg[2*p+1]);
        chk("ovc rise (R9)", int'(ovc_flag[2*p]), int'(m_ovc[2*p]));
        chk("ovc fall (R9)", int'(ovc_flag[2*p+1]), int'(m_ovc[2*p+1]));
      end
    end
  end

  task automatic tick(int n);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic train(int pin, int hi, int lo, int reps);
    for (int r = 0; r < reps; r++) begin
      pins[pin] = 1'b1; tick(hi);
      pins[pin] = 1'b0; tick(lo);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    cur_req = "R11";
    chk("reset valid", int'(pair_valid), 0);
    chk("reset flags", int'(ovc_flag), 0);
    chk("reset rise lanes", int'(pair_rise), 0);
    chk("reset fall lanes", int'(pair_fall), 0);

    cur_req = "R5";
    psc_val = 8'd0; arr_val = 16'd999; upd_go = 1'b1; tick(1); upd_go = 1'b0;
    cur_req = "R4";
    cnt_en = 1'b1; cap_arm = 4'hF; pair_ready = 2'b11; tick(5);

    cur_req = "R1";  train(0, 7, 13, 4);
    cur_req = "R10"; train(0, 1, 2, 3);
    cur_req = "R2";  train(0, 3, 20, 3);

    cur_req = "R9";
    pair_ready = 2'b00; train(0, 5, 5, 3); tick(4);
    cur_req = "R8";
    pair_ready[0] = 1'b1; tick(1); pair_ready[0] = 1'b0; tick(8);
    for (int i = 0; i < 60; i++) begin
      pair_ready = ((i % 3) == 0) ? 2'b11 : 2'b00;
      pins[0] = ((i % 5) < 2);
      tick(1);
    end
    pins[0] = 1'b0; pair_ready = 2'b11; tick(4);

    cur_req = "R3";
    src_sel = 2'b01; train(1, 4, 9, 3); train(0, 4, 9, 2);
    src_sel = 2'b10; train(3, 6, 6, 3); train(2, 6, 6, 2);
    src_sel = 2'b00; train(2, 3, 4, 3); train(1, 3, 4, 2);

    cur_req = "R6";
    for (int c = 1; c < 4; c++) begin
      in_div = {2'(c), 2'(c)};
      train(0, 2, 3, 10);
      train(2, 2, 3, 10);
    end

    cur_req = "R7";
    cap_arm = 4'b1010; train(0, 3, 3, 4); train(2, 3, 3, 2);
    cap_arm = 4'b0101; train(0, 3, 3, 4); train(2, 3, 3, 2);
    cap_arm = 4'hF; in_div = '0; tick(3);

    cur_req = "R5";
    psc_val = 8'd2; arr_val = 16'd40; train(0, 9, 17, 8);
    psc_val = 8'd1; arr_val = 16'd25; upd_go = 1'b1; tick(1); upd_go = 1'b0;
    train(0, 11, 14, 6);

    cur_req = "R4";
    cnt_en = 1'b0; train(0, 4, 4, 3);
    cnt_en = 1'b1; train(0, 4, 4, 3);
    psc_val = 8'd0; arr_val = 16'd7; upd_go = 1'b1; tick(1); upd_go = 1'b0;
    train(0, 5, 6, 6); train(2, 3, 9, 4);
    tick(6);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule